// File: doc/BRIEF.md
# Core Power Domain Sequencer

This block takes over the manual power-gating of a processor core's power domain. A single-cycle request names a core and a direction. The sequencer then performs the register-level steps that software would otherwise perform, one control change per cycle. It waits on the memory-power and logic-power-gate status handshakes, and on power-down it finally sets the core's halt bit. It holds one control word per core: clock enable, reset release, memory power, isolation, manual-mode select and a spare power-switch enable. It also holds a halt vector with one bit per core, and drives all of these as plain per-core outputs.

Each status wait is bounded by a window of `TMO_CYC` cycles. After the window closes, the status is sampled once more. If the core still has not answered, the sequencer stops at that step, raises an error and ignores new work until the error is cleared. Core 0 is the boot core and may never be gated. A power-down request for core 0 is answered with a one-cycle rejection pulse. A power-up request for a core whose unpowered status is already low finishes at once.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, every per-core control output is 0, every halt bit is 0, and done_o, busy_o, err_o and reject_o are 0.
- R2: A power-up request for a core with unpowered_i set first writes that core's word in one cycle: isolation set, and clock, reset release, memory, spare and manual cleared. Manual mode is then set, then the spare enable, then memory power, with one change per cycle.
- R3: After memory power is set, the sequencer waits for mem_pwr_ok_i of the core to read 1. It then sets the clock enable and waits for logic_pwr_ok_i to read 1.
- R4: The power-up ends by clearing isolation and then setting reset release. done_o pulses for one cycle with the last change, and the halt bit is left untouched.
- R5: A power-up request for a core with unpowered_i low gives a done_o pulse on the next cycle and changes no output.
- R6: The power-down order is fixed: set manual, clear reset release, clear the clock, set isolation, clear memory, wait for mem_pwr_ok_i = 0, clear the spare enable, wait for logic_pwr_ok_i = 0, set the core's halt bit. done_o pulses with the halt bit.
- R7: A power-down request for core 0 gives a one-cycle reject_o pulse, does not raise busy_o, and leaves every output unchanged.
- R8: If a status wait does not succeed within TMO_CYC+1 cycles plus one final sample, err_o rises and busy_o drops, with the controls frozen. Later requests are ignored while err_o is high, and err_clr_i returns the block to idle.
- R9: A status that first matches at the final sample, one cycle after the window closes, lets the sequence continue with no error.
- R10: Requests that arrive while busy_o is high are ignored, including a request that changes core_sel_i.
- R11: In idle, halt_rel_i clears the halt bit of the core on core_sel_i and leaves every other output unchanged.
- R12: When up_req_i and down_req_i arrive in the same cycle, the power-up is carried out.
- R13: The control and halt outputs of cores other than the one being sequenced hold their values for the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Single-cycle power-up request |
| down_req_i | input | 1 | Single-cycle power-down request |
| halt_rel_i | input | 1 | Single-cycle request to clear a halt bit |
| err_clr_i | input | 1 | Clears a timeout error |
| core_sel_i | input | IDX_W | Core index for a request |
| unpowered_i | input | N_CORES | Per-core status: 1 means the domain needs power-up |
| mem_pwr_ok_i | input | N_CORES | Per-core memory power status |
| logic_pwr_ok_i | input | N_CORES | Per-core logic power-gate status |
| clk_en_o | output | N_CORES | Core clock enable |
| rst_rel_o | output | N_CORES | Core reset release (1 = released) |
| mem_pwr_o | output | N_CORES | Core memory power enable |
| iso_o | output | N_CORES | Core output isolation |
| manual_o | output | N_CORES | Manual-mode select |
| spare_en_o | output | N_CORES | Spare power-switch enable |
| halt_o | output | N_CORES | Per-core halt bit |
| done_o | output | 1 | Sequence complete pulse |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Timeout error, held until cleared |
| reject_o | output | 1 | Core 0 power-down refused pulse |

## Verification
The bench records every change on the selected core's outputs and compares the exact event order against a model that applies the step list. A design that swaps two steps, or merges two of them into one cycle, shows up as a mismatch in that comparison. The status model delays each handshake by a chosen number of cycles. Delays of TMO_CYC+1 and TMO_CYC+2 sit on either side of the final-sample rule, so a design that drops the final sample or samples once too often gives the wrong error outcome. The bench also changes core_sel_i in the middle of a sequence, sends up and down requests together, sends a request while err_o is high, and tries to gate core 0. These catch a design that does not latch the core index, that picks the wrong priority, that leaves the error state early, or that gates the boot core.

// File: rtl/cpsq_pkg.sv
package cpsq_pkg;

  typedef struct packed {
    logic manual;
    logic iso;
    logic spare;
    logic mem;
    logic rst_rel;
    logic clk_en;
  } zone_t;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_UP_ISO,
    ST_UP_MAN,
    ST_UP_SPR,
    ST_UP_MEM,
    ST_UP_WMEM,
    ST_UP_CLK,
    ST_UP_WLG,
    ST_UP_NOISO,
    ST_UP_RST,
    ST_DN_MAN,
    ST_DN_RST,
    ST_DN_CLK,
    ST_DN_ISO,
    ST_DN_MEM,
    ST_DN_WMEM,
    ST_DN_SPR,
    ST_DN_WLG,
    ST_DN_HALT,
    ST_ERR
  } state_e;

endpackage

// File: rtl/cpsq_wait_timer.sv
module cpsq_wait_timer #(
  parameter int unsigned TMO_CYC = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic final_o
);
  localparam int unsigned CNT_W = $clog2(TMO_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else if (cnt_q == CNT_W'(TMO_CYC)) begin
      fin_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign final_o = fin_q;

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(TMO_CYC));

  a_r8_final_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !fin_q);

endmodule

// File: rtl/cpsq_zone_bank.sv
module cpsq_zone_bank
  import cpsq_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  localparam int unsigned IDX_W  = $clog2(N_CORES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   sel_i,
  input  zone_t              wr_word_i,
  input  logic               halt_set_i,
  input  logic               halt_clr_i,
  output zone_t              rd_word_o,
  output logic [N_CORES-1:0] clk_en_o,
  output logic [N_CORES-1:0] rst_rel_o,
  output logic [N_CORES-1:0] mem_pwr_o,
  output logic [N_CORES-1:0] iso_o,
  output logic [N_CORES-1:0] manual_o,
  output logic [N_CORES-1:0] spare_en_o,
  output logic [N_CORES-1:0] halt_o
);
  zone_t zq [N_CORES];
  logic [N_CORES-1:0] halt_q;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        zq[i]     <= '0;
        halt_q[i] <= 1'b0;
      end else begin
        if (wr_en_i && sel_i == IDX_W'(i)) zq[i] <= wr_word_i;
        if (halt_set_i && sel_i == IDX_W'(i)) halt_q[i] <= 1'b1;
        else if (halt_clr_i && sel_i == IDX_W'(i)) halt_q[i] <= 1'b0;
      end
    end

    assign clk_en_o[i]   = zq[i].clk_en;
    assign rst_rel_o[i]  = zq[i].rst_rel;
    assign mem_pwr_o[i]  = zq[i].mem;
    assign iso_o[i]      = zq[i].iso;
    assign manual_o[i]   = zq[i].manual;
    assign spare_en_o[i] = zq[i].spare;
  end

  assign halt_o    = halt_q;
  assign rd_word_o = zq[sel_i];

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cpsq_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned TMO_CYC = 50_000_000,
  localparam int unsigned IDX_W  = $clog2(N_CORES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               up_req_i,
  input  logic               down_req_i,
  input  logic               halt_rel_i,
  input  logic               err_clr_i,
  input  logic [IDX_W-1:0]   core_sel_i,
  input  logic [N_CORES-1:0] unpowered_i,
  input  logic [N_CORES-1:0] mem_pwr_ok_i,
  input  logic [N_CORES-1:0] logic_pwr_ok_i,
  output logic [N_CORES-1:0] clk_en_o,
  output logic [N_CORES-1:0] rst_rel_o,
  output logic [N_CORES-1:0] mem_pwr_o,
  output logic [N_CORES-1:0] iso_o,
  output logic [N_CORES-1:0] manual_o,
  output logic [N_CORES-1:0] spare_en_o,
  output logic [N_CORES-1:0] halt_o,
  output logic               done_o,
  output logic               busy_o,
  output logic               err_o,
  output logic               reject_o
);
  state_e st_q, st_d;
  logic [IDX_W-1:0] sel_q, bank_sel;
  zone_t cur, nxt;
  logic wr_en, halt_set, halt_clr, fin_done, rej, done_q, rej_q;
  logic m_ok, lg_ok, waiting, match, tmr_final;

  assign bank_sel = (st_q == ST_IDLE) ? core_sel_i : sel_q;
  assign m_ok     = mem_pwr_ok_i[sel_q];
  assign lg_ok    = logic_pwr_ok_i[sel_q];
  assign waiting  = st_q inside {ST_UP_WMEM, ST_UP_WLG, ST_DN_WMEM, ST_DN_WLG};

  always_comb begin
    match = 1'b0;
    unique case (st_q)
      ST_UP_WMEM: match = m_ok;
      ST_UP_WLG:  match = lg_ok;
      ST_DN_WMEM: match = !m_ok;
      ST_DN_WLG:  match = !lg_ok;
      default:    match = 1'b0;
    endcase
  end

  cpsq_wait_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (waiting && !match),
    .final_o (tmr_final)
  );

  cpsq_zone_bank #(.N_CORES(N_CORES)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .sel_i      (bank_sel),
    .wr_word_i  (nxt),
    .halt_set_i (halt_set),
    .halt_clr_i (halt_clr),
    .rd_word_o  (cur),
    .clk_en_o   (clk_en_o),
    .rst_rel_o  (rst_rel_o),
    .mem_pwr_o  (mem_pwr_o),
    .iso_o      (iso_o),
    .manual_o   (manual_o),
    .spare_en_o (spare_en_o),
    .halt_o     (halt_o)
  );

  always_comb begin
    st_d     = st_q;
    nxt      = cur;
    wr_en    = 1'b0;
    halt_set = 1'b0;
    halt_clr = 1'b0;
    fin_done = 1'b0;
    rej      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (up_req_i) begin
          if (unpowered_i[core_sel_i]) st_d = ST_UP_ISO;
          else fin_done = 1'b1;
        end else if (down_req_i) begin
          if (core_sel_i == '0) rej = 1'b1;
          else st_d = ST_DN_MAN;
        end else if (halt_rel_i) begin
          halt_clr = 1'b1;
        end
      end
      ST_UP_ISO: begin
        nxt = '0; nxt.iso = 1'b1; wr_en = 1'b1; st_d = ST_UP_MAN;
      end
      ST_UP_MAN:   begin nxt.manual = 1'b1; wr_en = 1'b1; st_d = ST_UP_SPR; end
      ST_UP_SPR:   begin nxt.spare  = 1'b1; wr_en = 1'b1; st_d = ST_UP_MEM; end
      ST_UP_MEM:   begin nxt.mem    = 1'b1; wr_en = 1'b1; st_d = ST_UP_WMEM; end
      ST_UP_CLK:   begin nxt.clk_en = 1'b1; wr_en = 1'b1; st_d = ST_UP_WLG; end
      ST_UP_NOISO: begin nxt.iso    = 1'b0; wr_en = 1'b1; st_d = ST_UP_RST; end
      ST_UP_RST: begin
        nxt.rst_rel = 1'b1; wr_en = 1'b1; st_d = ST_IDLE; fin_done = 1'b1;
      end
      ST_DN_MAN: begin nxt.manual  = 1'b1; wr_en = 1'b1; st_d = ST_DN_RST; end
      ST_DN_RST: begin nxt.rst_rel = 1'b0; wr_en = 1'b1; st_d = ST_DN_CLK; end
      ST_DN_CLK: begin nxt.clk_en  = 1'b0; wr_en = 1'b1; st_d = ST_DN_ISO; end
      ST_DN_ISO: begin nxt.iso     = 1'b1; wr_en = 1'b1; st_d = ST_DN_MEM; end
      ST_DN_MEM: begin nxt.mem     = 1'b0; wr_en = 1'b1; st_d = ST_DN_WMEM; end
      ST_DN_SPR: begin nxt.spare   = 1'b0; wr_en = 1'b1; st_d = ST_DN_WLG; end
      ST_DN_HALT: begin
        halt_set = 1'b1; st_d = ST_IDLE; fin_done = 1'b1;
      end
      ST_UP_WMEM: if (match) st_d = ST_UP_CLK;   else if (tmr_final) st_d = ST_ERR;
      ST_UP_WLG:  if (match) st_d = ST_UP_NOISO; else if (tmr_final) st_d = ST_ERR;
      ST_DN_WMEM: if (match) st_d = ST_DN_SPR;   else if (tmr_final) st_d = ST_ERR;
      ST_DN_WLG:  if (match) st_d = ST_DN_HALT;  else if (tmr_final) st_d = ST_ERR;
      ST_ERR:     if (err_clr_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_done;
      rej_q  <= rej;
      if (st_q == ST_IDLE && st_d != ST_IDLE) sel_q <= core_sel_i;
    end
  end

  assign done_o   = done_q;
  assign reject_o = rej_q;
  assign err_o    = (st_q == ST_ERR);
  assign busy_o   = (st_q != ST_IDLE) && (st_q != ST_ERR);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o);

  a_r8_err_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(waiting));

  a_r7_core0_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !err_o && down_req_i && !up_req_i && core_sel_i == '0)
      |=> $stable({clk_en_o[0], rst_rel_o[0], mem_pwr_o[0], iso_o[0],
                   manual_o[0], spare_en_o[0], halt_o[0]}) && !busy_o && reject_o);

  for (genvar i = 0; i < N_CORES; i++) begin : g_chk
    a_r3_clk_needs_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_en_o[i]) |-> mem_pwr_o[i] && iso_o[i] && spare_en_o[i]);

    a_r4_release_after_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_rel_o[i]) |-> !iso_o[i] && clk_en_o[i]);

    a_r6_halt_when_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(halt_o[i]) |-> !mem_pwr_o[i] && !spare_en_o[i] && !clk_en_o[i] && iso_o[i]);

    a_r13_unsel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && sel_q != IDX_W'(i))
        |=> $stable({clk_en_o[i], rst_rel_o[i], mem_pwr_o[i], iso_o[i],
                     manual_o[i], spare_en_o[i], halt_o[i]}));
  end

endmodule

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int TMO = 8;
  localparam int IW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 0, down_req = 0, halt_rel = 0, err_clr = 0;
  logic [IW-1:0] sel = '0;
  logic [N-1:0] up_n;
  logic [N-1:0] mem_ok, lg_ok;
  logic [N-1:0] clk_en, rst_rel, mem_pwr, iso, manual, spare, halt;
  logic done, busy, err, reject;

  core_pwr_seq #(.N_CORES(N), .TMO_CYC(TMO)) u_core_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .up_req_i(up_req), .down_req_i(down_req),
    .halt_rel_i(halt_rel), .err_clr_i(err_clr), .core_sel_i(sel),
    .unpowered_i(up_n), .mem_pwr_ok_i(mem_ok), .logic_pwr_ok_i(lg_ok),
    .clk_en_o(clk_en), .rst_rel_o(rst_rel), .mem_pwr_o(mem_pwr), .iso_o(iso),
    .manual_o(manual), .spare_en_o(spare), .halt_o(halt),
    .done_o(done), .busy_o(busy), .err_o(err), .reject_o(reject)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // status model: each handshake follows its source after dly cycles
  int dly = 2;
  logic [31:0] pm [N];
  logic [31:0] pl [N];
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      pm[i] <= {pm[i][30:0], mem_pwr[i]};
      pl[i] <= {pl[i][30:0], spare[i] & clk_en[i]};
    end
  end
  always_comb begin
    for (int i = 0; i < N; i++) begin
      mem_ok[i] = pm[i][dly-1];
      lg_ok[i]  = pl[i][dly-1];
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // word bits: 0 clk, 1 rst_rel, 2 mem, 3 spare, 4 iso, 5 manual, 6 halt
  function automatic logic [6:0] word_of(int i);
    return {halt[i], manual[i], iso[i], spare[i], mem_pwr[i], rst_rel[i], clk_en[i]};
  endfunction

  function automatic logic [13:0] step_of(int op, int k);
    if (op != 1) begin
      case (k)
        0: return {7'h10, 7'h2F};
        1: return {7'h20, 7'h00};
        2: return {7'h08, 7'h00};
        3: return {7'h04, 7'h00};
        4: return {7'h01, 7'h00};
        5: return {7'h00, 7'h10};
        default: return {7'h02, 7'h00};
      endcase
    end else begin
      case (k)
        0: return {7'h20, 7'h00};
        1: return {7'h00, 7'h02};
        2: return {7'h00, 7'h01};
        3: return {7'h10, 7'h00};
        4: return {7'h00, 7'h04};
        5: return {7'h00, 7'h08};
        default: return {7'h40, 7'h00};
      endcase
    end
  endfunction

  logic [6:0] mdl [N];
  int exp_ev [64];
  int exp_n;
  int act_ev [64];
  int act_n;
  bit mon_en = 0;
  int mon_core = 0;
  logic [6:0] prev_w;

  always @(negedge clk) begin
    if (mon_en) begin
      logic [6:0] w;
      w = word_of(mon_core);
      for (int b = 0; b < 7; b++)
        if (w[b] != prev_w[b] && act_n < 64) begin
          act_ev[act_n] = b*2 + int'(w[b]);
          act_n++;
        end
      prev_w = w;
    end
  end

  // op: 0 up, 1 down, 2 up and down together
  task automatic run_op(input int op, input int core, input int d, input bit exp_err,
                        input bit inj, input string req);
    int nsteps;
    logic [6:0] w, nw;
    bit got_done, got_err, got_rej, exp_rej, mism;
    int other;
    repeat (12) @(negedge clk);
    dly = d;
    exp_rej = (op == 1 && core == 0);
    if (exp_rej) nsteps = 0;
    else if (op != 1 && !up_n[core]) nsteps = 0;
    else if (exp_err) nsteps = (op == 1) ? 5 : 4;
    else nsteps = 7;
    w = mdl[core];
    exp_n = 0;
    for (int k = 0; k < nsteps; k++) begin
      logic [13:0] s;
      s = step_of(op, k);
      nw = (w & ~s[6:0]) | s[13:7];
      for (int b = 0; b < 7; b++)
        if (nw[b] != w[b]) begin exp_ev[exp_n] = b*2 + int'(nw[b]); exp_n++; end
      w = nw;
    end
    other = (core == 1) ? 3 : 1;
    prev_w = word_of(core);
    mon_core = core;
    act_n = 0;
    mon_en = 1;
    sel = IW'(core);
    up_req = (op != 1);
    down_req = (op != 0);
    @(negedge clk);
    up_req = 0; down_req = 0;
    got_done = 0; got_err = 0; got_rej = 0;
    for (int c = 0; c < 300; c++) begin
      if (done || err || reject) begin
        got_done = done; got_err = err; got_rej = reject;
        break;
      end
      if (inj && c == 3) begin sel = IW'(other); down_req = 1; up_req = 1; end
      if (inj && c == 4) begin sel = IW'(core); down_req = 0; up_req = 0; end
      @(negedge clk);
    end
    @(negedge clk);
    mon_en = 0;
    mism = (act_n != exp_n);
    for (int k = 0; k < exp_n && !mism; k++) if (act_ev[k] != exp_ev[k]) mism = 1;
    chk(!mism, {req, " step order"}, act_n, exp_n);
    chk(word_of(core) == w, {req, " final word"}, word_of(core), w);
    chk(got_done == (!exp_err && !exp_rej), {req, " done"}, got_done, !exp_err && !exp_rej);
    chk(got_err == exp_err, {req, " R8 err"}, got_err, exp_err);
    chk(got_rej == exp_rej, {req, " R7 reject"}, got_rej, exp_rej);
    for (int j = 0; j < N; j++)
      if (j != core) chk(word_of(j) == mdl[j], {req, " R13 other core hold"}, word_of(j), mdl[j]);
    mdl[core] = w;
    if (!exp_err && !exp_rej && nsteps == 7) up_n[core] = (op == 1);
    if (exp_err) begin
      chk(busy == 0, "R8 busy low in error", busy, 0);
      sel = IW'(core); up_req = 1;
      @(negedge clk); up_req = 0;
      repeat (3) @(negedge clk);
      chk(word_of(core) == w && err, "R8 request ignored in error", {word_of(core), err}, {w, 1'b1});
      err_clr = 1;
      @(negedge clk); err_clr = 0;
      chk(!err && !busy, "R8 error cleared", {err, busy}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    up_n = 4'b1110;
    for (int i = 0; i < N; i++) begin mdl[i] = '0; pm[i] = '0; pl[i] = '0; end
    repeat (3) @(negedge clk);
    chk({clk_en, rst_rel, mem_pwr, iso, manual, spare, halt, done, busy, err, reject} == '0,
        "R1 reset state", {done, busy, err, reject}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({clk_en, rst_rel, mem_pwr, iso, manual, spare, halt} == '0, "R1 after reset", halt, 0);

    run_op(0, 1, 3, 0, 0, "R2 R3 R4 power-up core1");
    run_op(0, 1, 3, 0, 0, "R5 already powered");
    run_op(1, 0, 2, 0, 0, "R7 core0 down");
    run_op(1, 1, 2, 0, 0, "R6 power-down core1");
    chk(halt[1] == 1, "R6 halt set", halt[1], 1);

    repeat (2) @(negedge clk);
    sel = 2'd1; halt_rel = 1;
    @(negedge clk); halt_rel = 0;
    @(negedge clk);
    mdl[1][6] = 1'b0;
    chk(halt[1] == 0, "R11 halt released", halt[1], 0);
    for (int j = 0; j < N; j++)
      chk(word_of(j) == mdl[j], "R11 others unchanged", word_of(j), mdl[j]);

    run_op(0, 2, TMO + 1, 0, 0, "R9 final sample match");
    run_op(0, 3, TMO + 2, 1, 0, "R8 timeout");
    run_op(2, 3, 2, 0, 0, "R12 up wins over down");
    run_op(1, 2, 4, 0, 1, "R10 busy ignores request");

    for (int it = 0; it < 16; it++) begin
      int core, op, d;
      core = 1 + int'($urandom % 3);
      d = 1 + int'($urandom % TMO);
      op = up_n[core] ? 0 : int'($urandom % 2);
      run_op(op, core, d, 0, ($urandom % 4) == 0, "R13 random sequence");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule